// File: doc/BRIEF.md
# Domain-Isolated Branch Target Buffer

This block sits beside the fetch stage and guesses, from the fetch address alone, whether that address holds a control transfer. When it does, the block also gives the kind of transfer and where it goes. Fetch can then be steered a cycle later, before the instruction bits have been decoded. Each stored entry records the domain (address space) that installed it. A lookup from any other domain never sees that entry, so one domain cannot train predictions that another domain will use.

Training comes only through a retire port. It is driven by instructions that have committed. Lookups never change the stored state, so wrong-path or squashed execution leaves no trace in the buffer.

A flush port removes stale or hostile state in one of two ways. It can clear every entry at once. It can also remove one domain's entries by walking the sets, one set per clock. During that walk a busy flag is high. While it is high, the domain being removed is already hidden from lookups and retire training is paused.

Top module: `dom_tagged_btb`

## Requirements
- R1: After reset, pred_hit and flush_busy are 0 and every lookup misses.
- R2: A lookup hits only when an entry matches both its address tag and its domain. The hit gives the stored kind (0 none, 1 conditional, 2 direct jump, 3 indirect jump) and target. The same address may hold separate entries for two domains.
- R3: Lookup results are registered. pred_hit, pred_kind and pred_target describe the lookup of the previous cycle. They reflect the contents before any retire write made in that same cycle.
- R4: A retire update whose address and domain match a stored entry overwrites that entry's kind and target in place.
- R5: A retire update of kind 0 removes the matching entry. If nothing matches, it installs nothing.
- R6: Each set has two ways. A new entry fills an invalid way first, lowest way first. Otherwise it replaces the way not most recently written by the retire port. Lookups do not affect this choice.
- R7: Lookups never install or modify entries. Only the retire port trains the buffer.
- R8: A flush request with flush_all set empties the whole buffer in one cycle. It is accepted even while a domain walk is running, and it ends that walk.
- R9: A flush request with flush_all clear removes only the entries of flush_dom. flush_busy rises in the next cycle and stays high for exactly SETS cycles (32 by default). Entries of other domains survive.
- R10: In the cycle a flush is accepted, and during a domain walk, lookups for the domain being removed miss. Retire updates are dropped in those cycles. A domain flush request made while flush_busy is high is ignored.
- R11: The set index is pc[ALIGN_W +: IDX_W] (pc[6:2] by default). The tag is the bits above it. pc[1:0] is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lkp_valid | input | 1 | Fetch lookup request |
| lkp_pc | input | PC_W | Fetch address |
| lkp_dom | input | DOM_W | Domain of the fetching context |
| pred_hit | output | 1 | Previous-cycle lookup found an entry |
| pred_kind | output | 2 | Predicted transfer kind |
| pred_target | output | PC_W | Predicted target address |
| ret_valid | input | 1 | Retired control transfer update |
| ret_pc | input | PC_W | Address of the retired instruction |
| ret_kind | input | 2 | Retired kind, 0 removes the entry |
| ret_target | input | PC_W | Resolved target |
| ret_dom | input | DOM_W | Domain of the retired instruction |
| flush_req | input | 1 | Flush request |
| flush_all | input | 1 | With flush_req: clear everything |
| flush_dom | input | DOM_W | Domain to remove when flush_all is 0 |
| flush_busy | output | 1 | Domain walk in progress |

## Verification
The bench places the same address under two domains and checks that each domain sees only its own target. A design that ignored the domain tag would leak one domain's target to the other.

It issues a lookup and a retire write to the same entry in one cycle. A design with a write-through read path would return the new value one cycle early.

It fills a set, repeats lookups on the older way, and then installs a third address. A design that refreshed recency on lookups would evict the wrong way.

During a domain walk, it probes an entry of the flushed domain in a set not yet walked. It also issues a second flush request, which must be ignored, and retires a new branch, which must be dropped. A design that reported the stale hit, restarted the walk, or accepted the training would show a wrong prediction or a wrong busy length.

// File: rtl/btb_pkg.sv
`timescale 1ns/1ps
package btb_pkg;
   localparam int unsigned KIND_W = 2;
   localparam int unsigned WAYS   = 2;

   typedef enum logic [KIND_W-1:0] {
      BK_NONE     = 2'd0,
      BK_COND     = 2'd1,
      BK_DIRECT   = 2'd2,
      BK_INDIRECT = 2'd3
   } br_kind_e;
endpackage

// File: rtl/btb_index_split.sv
`timescale 1ns/1ps
module btb_index_split #(
   parameter int PC_W    = 32,
   parameter int ALIGN_W = 2,
   parameter int IDX_W   = 5,
   parameter int TAG_W   = 25
) (
   input  logic [PC_W-1:0]  pc,
   output logic [IDX_W-1:0] idx,
   output logic [TAG_W-1:0] tag
);
   logic unused_align;

   assign idx          = pc[ALIGN_W +: IDX_W];
   assign tag          = pc[PC_W-1 -: TAG_W];
   assign unused_align = ^pc[ALIGN_W-1:0];
endmodule

// File: rtl/btb_way_array.sv
`timescale 1ns/1ps
module btb_way_array #(
   parameter int SETS   = 32,
   parameter int IDX_W  = 5,
   parameter int TAG_W  = 25,
   parameter int DOM_W  = 9,
   parameter int PC_W   = 32,
   parameter int KIND_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   // fetch-side read
   input  logic [IDX_W-1:0]  lk_idx,
   output logic              lk_valid,
   output logic [TAG_W-1:0]  lk_tag,
   output logic [DOM_W-1:0]  lk_dom,
   output logic [KIND_W-1:0] lk_kind,
   output logic [PC_W-1:0]   lk_tgt,
   // retire-side read
   input  logic [IDX_W-1:0]  rt_idx,
   output logic              rt_valid,
   output logic [TAG_W-1:0]  rt_tag,
   output logic [DOM_W-1:0]  rt_dom,
   // retire-side write
   input  logic              wr_en,
   input  logic              inv_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [DOM_W-1:0]  wr_dom,
   input  logic [KIND_W-1:0] wr_kind,
   input  logic [PC_W-1:0]   wr_tgt,
   // clearing
   input  logic              clr_all,
   input  logic              clr_en,
   input  logic [IDX_W-1:0]  clr_idx,
   input  logic [DOM_W-1:0]  clr_dom
);
   logic [SETS-1:0]   vld_q;
   logic [TAG_W-1:0]  tag_q  [SETS];
   logic [DOM_W-1:0]  dom_q  [SETS];
   logic [KIND_W-1:0] kind_q [SETS];
   logic [PC_W-1:0]   tgt_q  [SETS];

   assign lk_valid = vld_q[lk_idx];
   assign lk_tag   = tag_q[lk_idx];
   assign lk_dom   = dom_q[lk_idx];
   assign lk_kind  = kind_q[lk_idx];
   assign lk_tgt   = tgt_q[lk_idx];

   assign rt_valid = vld_q[rt_idx];
   assign rt_tag   = tag_q[rt_idx];
   assign rt_dom   = dom_q[rt_idx];

   // Valid bits carry reset; payload does not need it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (clr_all) begin
         vld_q <= '0;
      end else begin
         if (clr_en && (dom_q[clr_idx] == clr_dom)) begin
            vld_q[clr_idx] <= 1'b0;
         end
         if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
         end else if (inv_en) begin
            vld_q[wr_idx] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx]  <= wr_tag;
         dom_q[wr_idx]  <= wr_dom;
         kind_q[wr_idx] <= wr_kind;
         tgt_q[wr_idx]  <= wr_tgt;
      end
   end
endmodule

// File: rtl/btb_repl.sv
`timescale 1ns/1ps
module btb_repl #(
   parameter int SETS  = 32,
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] sel_idx,
   input  logic [1:0]       way_vld,
   output logic             victim,
   input  logic             touch_en,
   input  logic [IDX_W-1:0] touch_idx,
   input  logic             touch_way
);
   // lru_q[s] names the way to replace next in set s
   logic [SETS-1:0] lru_q;

   always_comb begin
      if (!way_vld[0])      victim = 1'b0;
      else if (!way_vld[1]) victim = 1'b1;
      else                  victim = lru_q[sel_idx];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lru_q <= '0;
      end else if (touch_en) begin
         lru_q[touch_idx] <= ~touch_way;
      end
   end
endmodule

// File: rtl/btb_flush_walk.sv
`timescale 1ns/1ps
module btb_flush_walk #(
   parameter int SETS  = 32,
   parameter int IDX_W = 5,
   parameter int DOM_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_req,
   input  logic             flush_all,
   input  logic [DOM_W-1:0] flush_dom,
   output logic             busy,
   output logic [IDX_W-1:0] walk_idx,
   output logic [DOM_W-1:0] walk_dom,
   output logic             clr_all,
   output logic             dom_accept
);
   localparam logic [IDX_W-1:0] LAST_SET = IDX_W'(SETS - 1);

   logic             busy_q;
   logic [IDX_W-1:0] cnt_q;
   logic [DOM_W-1:0] dom_q;

   assign clr_all    = flush_req && flush_all;
   assign dom_accept = flush_req && !flush_all && !busy_q;
   assign busy       = busy_q;
   assign walk_idx   = cnt_q;
   assign walk_dom   = dom_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         dom_q  <= '0;
      end else if (clr_all) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (dom_accept) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
         dom_q  <= flush_dom;
      end else if (busy_q) begin
         if (cnt_q == LAST_SET) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q  <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/dom_tagged_btb.sv
`timescale 1ns/1ps
module dom_tagged_btb
   import btb_pkg::*;
#(
   parameter int PC_W    = 32,
   parameter int DOM_W   = 9,
   parameter int ENTRIES = 64,
   parameter int ALIGN_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lkp_valid,
   input  logic [PC_W-1:0]   lkp_pc,
   input  logic [DOM_W-1:0]  lkp_dom,
   output logic              pred_hit,
   output logic [1:0]        pred_kind,
   output logic [PC_W-1:0]   pred_target,
   input  logic              ret_valid,
   input  logic [PC_W-1:0]   ret_pc,
   input  logic [1:0]        ret_kind,
   input  logic [PC_W-1:0]   ret_target,
   input  logic [DOM_W-1:0]  ret_dom,
   input  logic              flush_req,
   input  logic              flush_all,
   input  logic [DOM_W-1:0]  flush_dom,
   output logic              flush_busy
);
   localparam int SETS  = ENTRIES / WAYS;
   localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
   localparam int TAG_W = PC_W - IDX_W - ALIGN_W;

   // elaboration-time configuration checks
   if ((ENTRIES % WAYS) != 0 || SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_entries
      $error("dom_tagged_btb: ENTRIES must be a power of two and at least 4");
   end
   if (ALIGN_W < 1 || TAG_W < 1) begin : g_bad_pc
      $error("dom_tagged_btb: PC_W too small for ALIGN_W and index");
   end
   if (DOM_W < 1) begin : g_bad_dom
      $error("dom_tagged_btb: DOM_W must be positive");
   end

   // address split
   logic [IDX_W-1:0] lk_idx, rt_idx;
   logic [TAG_W-1:0] lk_tag, rt_tag;

   btb_index_split #(.PC_W(PC_W), .ALIGN_W(ALIGN_W), .IDX_W(IDX_W), .TAG_W(TAG_W))
      i_lk_split (.pc(lkp_pc), .idx(lk_idx), .tag(lk_tag));
   btb_index_split #(.PC_W(PC_W), .ALIGN_W(ALIGN_W), .IDX_W(IDX_W), .TAG_W(TAG_W))
      i_rt_split (.pc(ret_pc), .idx(rt_idx), .tag(rt_tag));

   // flush control
   logic             busy, clr_all, dom_accept;
   logic [IDX_W-1:0] walk_idx;
   logic [DOM_W-1:0] walk_dom;

   btb_flush_walk #(.SETS(SETS), .IDX_W(IDX_W), .DOM_W(DOM_W)) i_walk (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush_req  (flush_req),
      .flush_all  (flush_all),
      .flush_dom  (flush_dom),
      .busy       (busy),
      .walk_idx   (walk_idx),
      .walk_dom   (walk_dom),
      .clr_all    (clr_all),
      .dom_accept (dom_accept)
   );
   assign flush_busy = busy;

   // way storage
   logic [WAYS-1:0]   lk_v, rt_v, lk_hit, rt_hit, wr_sel, inv_sel;
   logic [TAG_W-1:0]  lk_t [WAYS];
   logic [TAG_W-1:0]  rt_t [WAYS];
   logic [DOM_W-1:0]  lk_d [WAYS];
   logic [DOM_W-1:0]  rt_d [WAYS];
   logic [KIND_W-1:0] lk_k [WAYS];
   logic [PC_W-1:0]   lk_g [WAYS];

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      btb_way_array #(
         .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W),
         .DOM_W(DOM_W), .PC_W(PC_W), .KIND_W(KIND_W)
      ) i_way (
         .clk      (clk),
         .rst_n    (rst_n),
         .lk_idx   (lk_idx),
         .lk_valid (lk_v[w]),
         .lk_tag   (lk_t[w]),
         .lk_dom   (lk_d[w]),
         .lk_kind  (lk_k[w]),
         .lk_tgt   (lk_g[w]),
         .rt_idx   (rt_idx),
         .rt_valid (rt_v[w]),
         .rt_tag   (rt_t[w]),
         .rt_dom   (rt_d[w]),
         .wr_en    (wr_sel[w]),
         .inv_en   (inv_sel[w]),
         .wr_idx   (rt_idx),
         .wr_tag   (rt_tag),
         .wr_dom   (ret_dom),
         .wr_kind  (ret_kind),
         .wr_tgt   (ret_target),
         .clr_all  (clr_all),
         .clr_en   (busy),
         .clr_idx  (walk_idx),
         .clr_dom  (walk_dom)
      );
      assign lk_hit[w] = lk_v[w] && (lk_t[w] == lk_tag) && (lk_d[w] == lkp_dom);
      assign rt_hit[w] = rt_v[w] && (rt_t[w] == rt_tag) && (rt_d[w] == ret_dom);
   end

   // retire-time training
   logic upd_ok, is_none, victim, wr_way;

   assign upd_ok  = ret_valid && !busy && !flush_req;
   assign is_none = (ret_kind == BK_NONE);
   assign wr_way  = (|rt_hit) ? rt_hit[1] : victim;

   for (genvar w = 0; w < WAYS; w++) begin : g_wsel
      assign wr_sel[w]  = upd_ok && !is_none && (wr_way == w[0]);
      assign inv_sel[w] = upd_ok && is_none && rt_hit[w];
   end

   btb_repl #(.SETS(SETS), .IDX_W(IDX_W)) i_repl (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_idx   (rt_idx),
      .way_vld   (rt_v),
      .victim    (victim),
      .touch_en  (upd_ok && !is_none),
      .touch_idx (rt_idx),
      .touch_way (wr_way)
   );

   // fetch-side prediction
   logic              hide;
   logic [KIND_W-1:0] sel_kind;
   logic [PC_W-1:0]   sel_tgt;

   assign hide = (clr_all)
              || (dom_accept && (flush_dom == lkp_dom))
              || (busy && (walk_dom == lkp_dom));

   always_comb begin
      sel_kind = '0;
      sel_tgt  = '0;
      for (int w = 0; w < WAYS; w++) begin
         sel_kind |= lk_k[w] & {KIND_W{lk_hit[w]}};
         sel_tgt  |= lk_g[w] & {PC_W{lk_hit[w]}};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pred_hit    <= 1'b0;
         pred_kind   <= '0;
         pred_target <= '0;
      end else if (lkp_valid && (|lk_hit) && !hide) begin
         pred_hit    <= 1'b1;
         pred_kind   <= sel_kind;
         pred_target <= sel_tgt;
      end else begin
         pred_hit    <= 1'b0;
         pred_kind   <= '0;
         pred_target <= '0;
      end
   end
endmodule

// File: rtl/dom_tagged_btb_chk.sv
`timescale 1ns/1ps
module dom_tagged_btb_chk #(
   parameter int DOM_W = 9,
   parameter int SETS  = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lkp_valid,
   input logic [DOM_W-1:0] lkp_dom,
   input logic             pred_hit,
   input logic [1:0]       pred_kind,
   input logic             flush_req,
   input logic             flush_all,
   input logic [DOM_W-1:0] flush_dom,
   input logic             flush_busy
);
   localparam int CNT_W = $clog2(SETS) + 1;

   logic             prev_lkp, prev_fa;
   logic [CNT_W-1:0] bcnt;
   logic [DOM_W-1:0] cap_dom;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_lkp <= 1'b0;
         prev_fa  <= 1'b0;
         bcnt     <= '0;
         cap_dom  <= '0;
      end else begin
         prev_lkp <= lkp_valid;
         prev_fa  <= flush_req && flush_all;
         bcnt     <= flush_busy ? bcnt + 1'b1 : '0;
         if (flush_req && !flush_all && !flush_busy) cap_dom <= flush_dom;
      end
   end

   // R3: a hit only follows a lookup in the previous cycle
   a_r3_hit_after_lookup: assert property (@(posedge clk) disable iff (!rst_n)
      !prev_lkp |-> !pred_hit);

   // R2: a hit never reports the "none" kind
   a_r2_hit_kind_real: assert property (@(posedge clk) disable iff (!rst_n)
      pred_hit |-> (pred_kind != 2'd0));

   // R8: the cycle after a full clear nothing can hit
   a_r8_clear_all_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (prev_fa && lkp_valid) |=> !pred_hit);

   // R9: busy only rises after an accepted domain request
   a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flush_busy) |-> $past(flush_req && !flush_all));

   // R9: busy never lasts more than SETS cycles
   a_r9_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
      flush_busy |-> (bcnt < CNT_W'(SETS)));

   // R9: busy does not end early without a full clear
   a_r9_busy_full: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_busy && (bcnt != CNT_W'(SETS - 1)) && !(flush_req && flush_all)) |=> flush_busy);

   // R10: the domain under removal never hits during the walk
   a_r10_walk_hides_dom: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_busy && lkp_valid && (lkp_dom == cap_dom)) |=> !pred_hit);
endmodule

bind dom_tagged_btb dom_tagged_btb_chk #(.DOM_W(DOM_W), .SETS(ENTRIES / 2)) i_btb_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lkp_valid  (lkp_valid),
   .lkp_dom    (lkp_dom),
   .pred_hit   (pred_hit),
   .pred_kind  (pred_kind),
   .flush_req  (flush_req),
   .flush_all  (flush_all),
   .flush_dom  (flush_dom),
   .flush_busy (flush_busy)
);

// File: tb/test_dom_tagged_btb.sv
`timescale 1ns/1ps
module test_dom_tagged_btb;
   localparam int PC_W = 32, DOM_W = 9, ENTRIES = 64, SETS = 32;

   logic             clk = 1'b0, rst_n = 1'b0;
   logic             lkp_valid = 1'b0;
   logic [PC_W-1:0]  lkp_pc = '0;
   logic [DOM_W-1:0] lkp_dom = '0;
   logic             pred_hit;
   logic [1:0]       pred_kind;
   logic [PC_W-1:0]  pred_target;
   logic             ret_valid = 1'b0;
   logic [PC_W-1:0]  ret_pc = '0;
   logic [1:0]       ret_kind = '0;
   logic [PC_W-1:0]  ret_target = '0;
   logic [DOM_W-1:0] ret_dom = '0;
   logic             flush_req = 1'b0, flush_all = 1'b0;
   logic [DOM_W-1:0] flush_dom = '0;
   logic             flush_busy;

   dom_tagged_btb #(.PC_W(PC_W), .DOM_W(DOM_W), .ENTRIES(ENTRIES), .ALIGN_W(2)) i_dom_tagged_btb (
      .clk(clk), .rst_n(rst_n),
      .lkp_valid(lkp_valid), .lkp_pc(lkp_pc), .lkp_dom(lkp_dom),
      .pred_hit(pred_hit), .pred_kind(pred_kind), .pred_target(pred_target),
      .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_kind(ret_kind),
      .ret_target(ret_target), .ret_dom(ret_dom),
      .flush_req(flush_req), .flush_all(flush_all), .flush_dom(flush_dom),
      .flush_busy(flush_busy)
   );

   always #2.5 clk = ~clk;   // 200 MHz

   int n_vec = 0, n_bad = 0, busy_seen = 0;
   bit done = 1'b0;

   always @(negedge clk) if (flush_busy) busy_seen++;

   function automatic logic [PC_W-1:0] mk_pc(int tag, int idx);
      return (PC_W'(tag) << 7) | (PC_W'(idx) << 2);
   endfunction

   task automatic expect_pred(string req, logic hit, logic [1:0] kind, logic [PC_W-1:0] tgt);
      n_vec++;
      if (pred_hit !== hit || (hit && (pred_kind !== kind || pred_target !== tgt))) begin
         n_bad++;
         $display("FAIL %s: hit=%0b kind=%0d tgt=%h, expected hit=%0b kind=%0d tgt=%h",
                  req, pred_hit, pred_kind, pred_target, hit, kind, tgt);
      end
   endtask

   task automatic expect_val(string req, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d, expected %0d", req, act, exp);
      end
   endtask

   task automatic probe(string req, logic [PC_W-1:0] pc, int dom,
                        logic hit, logic [1:0] kind, logic [PC_W-1:0] tgt);
      @(negedge clk);
      lkp_valid = 1'b1; lkp_pc = pc; lkp_dom = DOM_W'(dom);
      @(negedge clk);
      lkp_valid = 1'b0;
      expect_pred(req, hit, kind, tgt);
   endtask

   task automatic train(logic [PC_W-1:0] pc, logic [1:0] kind, logic [PC_W-1:0] tgt, int dom);
      @(negedge clk);
      ret_valid = 1'b1; ret_pc = pc; ret_kind = kind; ret_target = tgt; ret_dom = DOM_W'(dom);
      @(negedge clk);
      ret_valid = 1'b0;
   endtask

   task automatic wipe();
      @(negedge clk);
      flush_req = 1'b1; flush_all = 1'b1;
      @(negedge clk);
      flush_req = 1'b0; flush_all = 1'b0;
   endtask

   task automatic t_reset();
      expect_val("R1 pred_hit after reset", int'(pred_hit), 0);
      expect_val("R1 flush_busy after reset", int'(flush_busy), 0);
      probe("R1 empty lookup", mk_pc(3, 4), 5, 1'b0, 2'd0, '0);
   endtask

   task automatic t_domain_tag();
      logic [PC_W-1:0] a = mk_pc(3, 4);
      train(a, 2'd2, 32'h0000_4000, 5);
      probe("R2 own domain hits", a, 5, 1'b1, 2'd2, 32'h0000_4000);
      probe("R2 other domain misses", a, 6, 1'b0, 2'd0, '0);
      probe("R11 low pc bits ignored", a | 32'h3, 5, 1'b1, 2'd2, 32'h0000_4000);
      probe("R11 tag mismatch misses", mk_pc(4, 4), 5, 1'b0, 2'd0, '0);
      probe("R11 index mismatch misses", mk_pc(3, 5), 5, 1'b0, 2'd0, '0);
      train(mk_pc(9, 15), 2'd1, 32'h0000_1100, 1);
      train(mk_pc(9, 15), 2'd3, 32'h0000_2200, 2);
      probe("R2 same pc domain 1", mk_pc(9, 15), 1, 1'b1, 2'd1, 32'h0000_1100);
      probe("R2 same pc domain 2", mk_pc(9, 15), 2, 1'b1, 2'd3, 32'h0000_2200);
      probe("R2 same pc unknown domain", mk_pc(9, 15), 7, 1'b0, 2'd0, '0);
   endtask

   task automatic t_same_cycle();
      logic [PC_W-1:0] b = mk_pc(5, 9);
      @(negedge clk);
      lkp_valid = 1'b1; lkp_pc = b; lkp_dom = 1;
      ret_valid = 1'b1; ret_pc = b; ret_kind = 2'd2; ret_target = 32'h5000; ret_dom = 1;
      @(negedge clk);
      lkp_valid = 1'b0; ret_valid = 1'b0;
      expect_pred("R3 install not seen same cycle", 1'b0, 2'd0, '0);
      probe("R3 install seen next cycle", b, 1, 1'b1, 2'd2, 32'h5000);
      @(negedge clk);
      lkp_valid = 1'b1; lkp_pc = b; lkp_dom = 1;
      ret_valid = 1'b1; ret_pc = b; ret_kind = 2'd2; ret_target = 32'h6000; ret_dom = 1;
      @(negedge clk);
      lkp_valid = 1'b0; ret_valid = 1'b0;
      expect_pred("R3 old target on same-cycle update", 1'b1, 2'd2, 32'h5000);
      probe("R4 target overwritten", b, 1, 1'b1, 2'd2, 32'h6000);
   endtask

   task automatic t_none_kind();
      train(mk_pc(6, 12), 2'd1, 32'h7000, 1);
      probe("R5 entry present", mk_pc(6, 12), 1, 1'b1, 2'd1, 32'h7000);
      train(mk_pc(6, 12), 2'd0, 32'h0, 1);
      probe("R5 kind none removes", mk_pc(6, 12), 1, 1'b0, 2'd0, '0);
      train(mk_pc(7, 12), 2'd0, 32'h0, 1);
      probe("R5 kind none installs nothing", mk_pc(7, 12), 1, 1'b0, 2'd0, '0);
      probe("R7 miss lookup", mk_pc(8, 20), 1, 1'b0, 2'd0, '0);
      probe("R7 lookup did not install", mk_pc(8, 20), 1, 1'b0, 2'd0, '0);
   endtask

   task automatic t_replacement();
      train(mk_pc(1, 7), 2'd2, 32'h0100, 2);   // way 0
      train(mk_pc(2, 7), 2'd2, 32'h0200, 2);   // way 1
      for (int i = 0; i < 3; i++) probe("R7 repeated lookup", mk_pc(1, 7), 2, 1'b1, 2'd2, 32'h0100);
      train(mk_pc(3, 7), 2'd3, 32'h0300, 2);
      probe("R6 older write evicted", mk_pc(1, 7), 2, 1'b0, 2'd0, '0);
      probe("R6 newer way kept", mk_pc(2, 7), 2, 1'b1, 2'd2, 32'h0200);
      probe("R6 new entry present", mk_pc(3, 7), 2, 1'b1, 2'd3, 32'h0300);
      train(mk_pc(2, 7), 2'd1, 32'h0222, 2);   // in-place update refreshes way 1
      train(mk_pc(4, 7), 2'd2, 32'h0400, 2);
      probe("R4 updated entry kept", mk_pc(2, 7), 2, 1'b1, 2'd1, 32'h0222);
      probe("R6 way not refreshed evicted", mk_pc(3, 7), 2, 1'b0, 2'd0, '0);
      probe("R6 newest install present", mk_pc(4, 7), 2, 1'b1, 2'd2, 32'h0400);
   endtask

   task automatic t_flush_all();
      train(mk_pc(20, 3), 2'd2, 32'h9000, 6);
      train(mk_pc(21, 8), 2'd1, 32'h9100, 7);
      wipe();
      probe("R8 clear all", mk_pc(20, 3), 6, 1'b0, 2'd0, '0);
      probe("R8 clear all other domain", mk_pc(21, 8), 7, 1'b0, 2'd0, '0);
      train(mk_pc(22, 30), 2'd2, 32'h9200, 6);
      @(negedge clk);
      flush_req = 1'b1; flush_dom = 8;
      @(negedge clk);
      flush_req = 1'b0;
      repeat (3) @(negedge clk);
      flush_req = 1'b1; flush_all = 1'b1;
      @(negedge clk);
      flush_req = 1'b0; flush_all = 1'b0;
      expect_val("R8 clear all ends walk", int'(flush_busy), 0);
      probe("R8 clear all during walk", mk_pc(22, 30), 6, 1'b0, 2'd0, '0);
   endtask

   task automatic t_domain_flush();
      wipe();
      train(mk_pc(10, 0), 2'd2, 32'hA000, 3);
      train(mk_pc(11, 0), 2'd3, 32'hB000, 4);
      train(mk_pc(12, 31), 2'd1, 32'hC000, 3);
      train(mk_pc(13, 31), 2'd2, 32'hD000, 4);
      @(negedge clk);
      busy_seen = 0;
      flush_req = 1'b1; flush_all = 1'b0; flush_dom = 3;
      @(negedge clk);
      flush_req = 1'b0;
      expect_val("R9 busy rises next cycle", int'(flush_busy), 1);
      lkp_valid = 1'b1; lkp_pc = mk_pc(12, 31); lkp_dom = 3;
      ret_valid = 1'b1; ret_pc = mk_pc(14, 5); ret_kind = 2'd2; ret_target = 32'hE000; ret_dom = 4;
      flush_req = 1'b1; flush_dom = 4;                     // must be ignored
      @(negedge clk);
      lkp_valid = 1'b0; ret_valid = 1'b0; flush_req = 1'b0;
      expect_pred("R10 flushed domain hidden during walk", 1'b0, 2'd0, '0);
      lkp_valid = 1'b1; lkp_pc = mk_pc(13, 31); lkp_dom = 4;
      @(negedge clk);
      lkp_valid = 1'b0;
      expect_pred("R10 other domain visible during walk", 1'b1, 2'd2, 32'hD000);
      repeat (2 * SETS) @(negedge clk);
      expect_val("R9 busy length", busy_seen, SETS);
      probe("R9 domain entry set 0 removed", mk_pc(10, 0), 3, 1'b0, 2'd0, '0);
      probe("R9 domain entry set 31 removed", mk_pc(12, 31), 3, 1'b0, 2'd0, '0);
      probe("R9 other domain set 0 kept", mk_pc(11, 0), 4, 1'b1, 2'd3, 32'hB000);
      probe("R10 ignored request kept domain", mk_pc(13, 31), 4, 1'b1, 2'd2, 32'hD000);
      probe("R10 update dropped during walk", mk_pc(14, 5), 4, 1'b0, 2'd0, '0);
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_domain_tag();
      t_same_cycle();
      t_none_kind();
      t_replacement();
      t_flush_all();
      t_domain_flush();
      done = 1'b1;
      finish_run();
   end

   initial begin
      #(20000 * 5);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         finish_run();
      end
   end
endmodule